// File: doc/BRIEF.md
# Pedestal Correction Datapath

This block removes a per-channel baseline from a stream of 12-bit converter samples. A host loads a table of correction words, one per channel, through a sequential write port. Each word is the negated baseline in 12-bit two's complement, so the correction itself is a single addition. The table holds 1024 words, of which at most 1008 can be loaded. The host must load the words in the reverse of the order in which channels later arrive. A single pointer counts up on each host load and counts down on each arriving sample, so the first sample is paired with the last word loaded.

A 5-bit control word picks one of three behaviours. In bypass, the sample is passed through as is. In correction, the sample plus the sign-extended table word is output. In table readback, the sign-extended table word is output in place of the sample, which lets the host verify the stored table. Every result is a 16-bit two's complement value with a one-cycle latency. A full-scale sample (all twelve bits set) is an overflow marker and is never altered.

Top module: `ped_sub_top`

## Requirements
- R1: After synchronous reset, `res_valid` and `res_data` are 0, the table pointer is 0, and the control word is 0, which selects bypass.
- R2: `ctrl_we` loads `ctrl_data`. Bit 1 enables correction and bit 2 enables sample transfer. Bits 0, 3 and 4 are held but do not change the result. A new word applies from the next cycle.
- R3: A host load (`ped_we`) stores `ped_wdata` at the pointer and then increments the pointer. A load is ignored once the pointer has reached 1008.
- R4: `clr_addr` returns the pointer to 0, overriding any load or sample in the same cycle.
- R5: For each sample (`smp_valid`), `res_valid` is 1 in the next cycle and `res_data` holds that sample's result. The sample uses the table word at pointer-1, and the pointer then decrements, so table words are used in the reverse of their load order.
- R6: With bit 1 = 1 and bit 2 = 1, the result is the zero-extended sample plus the sign-extended 12-bit table word, as 16-bit two's complement. Bit 15 is 1 exactly when the result is negative.
- R7: With bit 1 = 1 and bit 2 = 1, a sample equal to 4095 is output as 0x0FFF whatever the table word is.
- R8: With bit 1 = 0, the result is the zero-extended sample. The pointer still decrements on each sample.
- R9: With bit 1 = 1 and bit 2 = 0, the result is the sign-extended table word, and the sample value is ignored.
- R10: A sample that arrives while the pointer is 0 uses a table word of 0, and the pointer stays at 0.
- R11: A host load in the same cycle as a sample is dropped: nothing is stored and the pointer does not increment.
- R12: `res_valid` is 0 in every cycle that follows a cycle without a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_addr | input | 1 | Return the table pointer to 0 |
| ctrl_we | input | 1 | Load the control word |
| ctrl_data | input | 5 | Control word (bit 1 correct, bit 2 transfer) |
| ped_we | input | 1 | Host table load strobe |
| ped_wdata | input | 12 | Negated baseline, two's complement |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Unsigned converter sample |
| res_valid | output | 1 | Result strobe, one cycle after the sample |
| res_data | output | 16 | Signed result |

## Verification
The bench loads a table of mixed-sign words, including the most negative 12-bit value, and reads the table back. It checks that the words return in reverse order and properly sign-extended. A pointer that ran forwards, or a zero extension of the table word, would return the wrong words. It fills the table to exactly 1008 entries and then attempts one more load. A limit that is off by one would store the extra word and output it first. Further cases check the following: the overflow marker is kept even when the table word is negative, bypass still moves the pointer, the pointer is cleared in the middle of a load, a load that collides with a sample is dropped, and a sample at an empty pointer gets no correction.

// File: rtl/ped_pkg.sv
package ped_pkg;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        MODE_BYPASS   = 2'd0,
        MODE_CORRECT  = 2'd1,
        MODE_READBACK = 2'd2
    } ped_mode_e;

    // Bit 1 enables correction, bit 2 enables sample transfer.
    // The remaining bits do not take part in this datapath.
    function automatic ped_mode_e decode_mode(input logic [CTRL_W-1:0] w);
        ped_mode_e m;
        casez (w)
            5'b???0?: m = MODE_BYPASS;
            5'b??11?: m = MODE_CORRECT;
            5'b??01?: m = MODE_READBACK;
            default:  m = MODE_BYPASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ped_addr_ctr.sv
module ped_addr_ctr #(
    parameter int ADDR_W   = 10,
    parameter int LOAD_MAX = 1008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ped_ok,
    output logic              wr_ok
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(LOAD_MAX);

    logic at_limit;

    assign at_limit = (ptr == LIMIT);
    assign ped_ok   = (ptr != '0);
    assign rd_addr  = ptr - 1'b1;
    assign wr_ok    = wr_req && !rd_req && !clr && !rst && !at_limit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (rd_req) begin
            if (ped_ok) ptr <= ptr - 1'b1;
        end else if (wr_ok) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ped_mem.sv
module ped_mem #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 12,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/ped_correct.sv
module ped_correct
    import ped_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int RES_W = 16
) (
    input  ped_mode_e         mode,
    input  logic [SMP_W-1:0]  smp,
    input  logic [SMP_W-1:0]  ped,
    input  logic              ped_ok,
    output logic [RES_W-1:0]  res
);
    localparam int EXT_W = RES_W - SMP_W;

    logic [RES_W-1:0] smp_x;
    logic [RES_W-1:0] ped_x;
    logic             is_ovf;

    assign smp_x  = {{EXT_W{1'b0}}, smp};
    assign ped_x  = ped_ok ? {{EXT_W{ped[SMP_W-1]}}, ped} : '0;
    assign is_ovf = &smp;

    always_comb begin
        unique case (mode)
            MODE_CORRECT:  res = is_ovf ? smp_x : smp_x + ped_x;
            MODE_READBACK: res = ped_x;
            default:       res = smp_x;
        endcase
    end
endmodule

// File: rtl/ped_sub_top.sv
module ped_sub_top
    import ped_pkg::*;
#(
    parameter int SMP_W    = 12,
    parameter int RES_W    = 16,
    parameter int DEPTH    = 1024,
    parameter int LOAD_MAX = 1008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_addr,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic              ped_we,
    input  logic [SMP_W-1:0]  ped_wdata,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [CTRL_W-1:0] ctrl_q;
    ped_mode_e         mode;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic              ped_ok;
    logic              wr_ok;
    logic [SMP_W-1:0]  ped_word;
    logic [RES_W-1:0]  res_next;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_data;
    end

    assign mode = decode_mode(ctrl_q);

    ped_addr_ctr #(.ADDR_W(ADDR_W), .LOAD_MAX(LOAD_MAX)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_addr),
        .wr_req  (ped_we),
        .rd_req  (smp_valid),
        .ptr     (ptr),
        .rd_addr (rd_addr),
        .ped_ok  (ped_ok),
        .wr_ok   (wr_ok)
    );

    ped_mem #(.DEPTH(DEPTH), .DATA_W(SMP_W)) u_mem (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (ptr),
        .wdata (ped_wdata),
        .raddr (rd_addr),
        .rdata (ped_word)
    );

    ped_correct #(.SMP_W(SMP_W), .RES_W(RES_W)) u_corr (
        .mode   (mode),
        .smp    (smp_data),
        .ped    (ped_word),
        .ped_ok (ped_ok),
        .res    (res_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= smp_valid;
            if (smp_valid) res_data <= res_next;
        end
    end
endmodule

// File: rtl/ped_sub_chk.sv
module ped_sub_chk
    import ped_pkg::*;
#(
    parameter int SMP_W    = 12,
    parameter int RES_W    = 16,
    parameter int ADDR_W   = 10,
    parameter int LOAD_MAX = 1008
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_addr,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_data,
    input ped_mode_e         mode,
    input logic [ADDR_W-1:0] ptr,
    input logic              res_valid,
    input logic [RES_W-1:0]  res_data
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !res_valid);  // R1

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        ptr <= ADDR_W'(LOAD_MAX));  // R3

    AST_CLR_PTR: assert property (@(posedge clk) disable iff (rst)
        clr_addr |=> ptr == '0);  // R4

    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> res_valid);  // R5

    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == MODE_CORRECT && (&smp_data))
        |=> res_data == RES_W'($past(smp_data)));  // R7

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == MODE_BYPASS)
        |=> res_data == RES_W'($past(smp_data)));  // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !res_valid);  // R12
endmodule

bind ped_sub_top ped_sub_chk #(
    .SMP_W(SMP_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .LOAD_MAX(LOAD_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_addr  (clr_addr),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .mode      (mode),
    .ptr       (ptr),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/ped_sub_top_tb.sv
module ped_sub_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_addr = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [4:0]  ctrl_data = '0;
    logic        ped_we = 1'b0;
    logic [11:0] ped_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        res_valid;
    logic [15:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] C_BYPASS = 5'b00100;
    localparam logic [4:0] C_CORR   = 5'b00110;
    localparam logic [4:0] C_RDBK   = 5'b00010;

    always #5 clk = ~clk;

    ped_sub_top u_dut (
        .clk(clk), .rst(rst), .clr_addr(clr_addr), .ctrl_we(ctrl_we),
        .ctrl_data(ctrl_data), .ped_we(ped_we), .ped_wdata(ped_wdata),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [4:0] w);
        ctrl_we = 1'b1; ctrl_data = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic do_clr();
        clr_addr = 1'b1;
        @(negedge clk);
        clr_addr = 1'b0;
    endtask

    task automatic load(input logic [11:0] v);
        ped_we = 1'b1; ped_wdata = v;
        @(negedge clk);
        ped_we = 1'b0;
    endtask

    task automatic sample(input logic [11:0] d, input logic [15:0] exp, input string req);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
        check(res_valid === 1'b1 && res_data === exp, req, res_data, exp);
    endtask

    task automatic load_four();
        do_clr();
        load(12'hF9C); load(12'hFFB); load(12'h014); load(12'h800);
    endtask

    task automatic t_reset();
        check(res_valid === 1'b0, "R1 valid", {15'd0, res_valid}, 16'h0000);
        check(res_data === 16'h0000, "R1 data", res_data, 16'h0000);
        sample(12'h005, 16'h0005, "R1 ctrl defaults to bypass");
        @(negedge clk);
        check(res_valid === 1'b0, "R12 no sample no valid", {15'd0, res_valid}, 16'h0000);
    endtask

    task automatic t_readback();
        load_four();
        set_ctrl(5'b11011);
        sample(12'h123, 16'hF800, "R9 R5 R2 last loaded first");
        sample(12'h000, 16'h0014, "R9 R5 second");
        sample(12'hFFF, 16'hFFFB, "R9 third");
        sample(12'h456, 16'hFF9C, "R9 first loaded last");
        sample(12'h456, 16'h0000, "R10 empty pointer readback");
    endtask

    task automatic t_correct();
        load_four();
        set_ctrl(C_CORR);
        sample(12'd50,   16'hF832, "R6 negative result sign");
        check(res_data[15] === 1'b1, "R6 bit15", res_data, 16'hF832);
        sample(12'd200,  16'h00DC, "R6 positive word");
        sample(12'd3000, 16'h0BB3, "R6 small negative word");
        sample(12'd4095, 16'h0FFF, "R7 overflow kept");
        sample(12'd77,   16'h004D, "R10 empty pointer correct");
    endtask

    task automatic t_bypass();
        load_four();
        set_ctrl(C_BYPASS);
        sample(12'd300,  16'h012C, "R8 bypass value");
        sample(12'd4095, 16'h0FFF, "R8 bypass full scale");
        set_ctrl(C_RDBK);
        sample(12'd0, 16'hFFFB, "R8 pointer moved in bypass");
    endtask

    task automatic t_limit();
        do_clr();
        for (int i = 0; i < 1008; i++) load(12'(i));
        load(12'h777);
        set_ctrl(C_RDBK);
        sample(12'd0, 16'h03EF, "R3 load beyond 1008 ignored");
        sample(12'd0, 16'h03EE, "R3 next word");
    endtask

    task automatic t_clear();
        do_clr();
        load(12'h0AA); load(12'h0BB); load(12'h0CC);
        do_clr();
        load(12'h123);
        set_ctrl(C_RDBK);
        sample(12'd0, 16'h0123, "R4 clear mid load");
        sample(12'd0, 16'h0000, "R4 pointer restarted");
    endtask

    task automatic t_collide();
        do_clr();
        load(12'h011); load(12'h022);
        set_ctrl(C_RDBK);
        ped_we = 1'b1; ped_wdata = 12'h033;
        sample(12'd0, 16'h0022, "R11 sample wins");
        ped_we = 1'b0;
        sample(12'd0, 16'h0011, "R11 load dropped");
        sample(12'd0, 16'h0000, "R11 pointer not bumped");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_correct();
        t_bypass();
        t_limit();
        t_clear();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual 0x0000 expected 0x0001");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule